// File: doc/BRIEF.md
# Interrupt Presentation and Poll Unit

This block keeps two 32-bit state registers, an interrupt presentation register and an interrupt type mask, and a poll mask register. Each of the two state registers can be written three ways over a simple register bus: a direct overwrite at its base offset, a set-bits alias at base+1 and a clear-bits alias at base+2. An alias write is staged for one cycle, so reading the alias shows the staged word. The following cycle the staged word is folded into the state register and the alias returns to its idle value: all zeros for the set-bits alias, all ones for the clear-bits alias. Attention sources can also set presentation bits directly through a per-bit set request.

From the presentation register, one gate bit of the type mask and the poll mask, the block forms a registered poll status word. Its top four bits form a level interrupt toward the local error logic. Software clears the cause with the clear-bits alias or by unmasking and masking. Bit numbering follows the convention that bit k of a word is vector index 31-k, so bit 0 is the most significant bit.

Top module: `irq_poll_unit`

## Requirements
- R1: After reset the presentation register and the type mask read 0, the poll mask reads 0xFFFFFFFF, the set-bits aliases read 0, the clear-bits aliases read 0xFFFFFFFF, and the poll status and the interrupt are 0.
- R2: A bus write to offset 0x00 (presentation), 0x0C (type mask) or 0x13 (poll mask) replaces that register at the write's clock edge.
- R3: A write to offset 0x01 makes that alias read the written word for one cycle. On the next edge the word is ORed into the presentation register and the alias returns to 0.
- R4: A write to offset 0x02 makes that alias read the written word for one cycle. On the next edge the presentation register is ANDed with it and the alias returns to 0xFFFFFFFF.
- R5: Offsets 0x0D and 0x0E act on the type mask exactly as R3 and R4 act on the presentation register.
- R6: Each set-request bit set in a cycle sets the matching presentation bit at that edge. This holds even when a direct write or a staged clear in the same cycle would clear that bit.
- R7: Poll status bit 3 (index 28) becomes 1 one edge after the presentation register is nonzero while type mask bit 0 (index 31) and poll mask bit 3 (index 28) are 0. Otherwise it becomes 0.
- R8: Poll status bit 7 (index 24) follows the rule of R7 using poll mask bit 7 (index 24).
- R9: All poll status bits other than bits 3 and 7 are always 0.
- R10: The interrupt output is 1 exactly while any of poll status bits 0 to 3 (indices 31:28) is 1. Bit 7 alone never raises it.
- R11: The read data returns, without delay, the register at the read offset: 0x00, 0x01, 0x02, 0x0C, 0x0D, 0x0E, 0x13, or the poll status at 0x14. Any other offset reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | 5 | Bus write offset |
| wr_data | input | 32 | Bus write data |
| set_req | input | 32 | Per-bit set requests from attention sources |
| rd_addr | input | 5 | Bus read offset |
| rd_data | output | 32 | Read data for rd_addr |
| poll_status | output | 32 | Registered poll status word |
| local_err_irq | output | 1 | Level interrupt from the top four status bits |

## Verification
The hardest case to reach from the ports is a set request that collides with a clear of the same bit. The clear may be a direct overwrite in the same cycle, or a clear-bits alias that was staged one cycle earlier and lands on the edge where the request arrives. The stimulus produces both cases on purpose: it writes the clear alias and raises the set request at the very next negative edge. A long random phase then mixes alias writes, set requests and mask changes against a behavioural model that is compared every clock.

// File: rtl/irqp_pkg.sv
package irqp_pkg;

  // Register offsets; each state register has its aliases at base+1 and base+2
  localparam int unsigned OFF_PRES  = 0;
  localparam int unsigned OFF_TYPE  = 12;
  localparam int unsigned OFF_PMASK = 19;
  localparam int unsigned OFF_STAT  = 20;

  // Bit numbers in MSB-first convention (bit k is vector index WIDTH-1-k)
  localparam int unsigned TYPE_GATE_BIT = 0;
  localparam int unsigned POLL_BIT_A    = 3;
  localparam int unsigned POLL_BIT_B    = 7;
  localparam int unsigned IRQ_FIELD_W   = 4;

  typedef enum logic [1:0] {
    WK_NONE   = 2'd0,
    WK_DIRECT = 2'd1,
    WK_OR     = 2'd2,
    WK_AND    = 2'd3
  } wr_kind_e;

  function automatic int unsigned msb_idx(input int unsigned width, input int unsigned k);
    return width - 1 - k;
  endfunction

  function automatic logic poll_watched(input int unsigned k);
    return (k == POLL_BIT_A) || (k == POLL_BIT_B);
  endfunction

endpackage

// File: rtl/irqp_alias_reg.sv
module irqp_alias_reg
  import irqp_pkg::*;
#(
  parameter int unsigned     DW      = 32,
  parameter logic [DW-1:0]   RST_VAL = '0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  wr_kind_e       kind,
  input  logic [DW-1:0]  wdata,
  input  logic [DW-1:0]  set_req,
  output logic [DW-1:0]  value,
  output logic [DW-1:0]  or_view,
  output logic [DW-1:0]  and_view
);

  localparam logic [DW-1:0] ALL_ZERO = '0;
  localparam logic [DW-1:0] ALL_ONE  = '1;

  logic [DW-1:0] val_q, or_q, and_q, val_d, base_w;

  // Named events for the checks
  logic or_pending, and_pending, set_hit, wr_main;
  assign or_pending  = |or_q;
  assign and_pending = ~&and_q;
  assign set_hit     = |set_req;
  assign wr_main     = (kind == WK_DIRECT);

  // Staged set, then staged clear, then set requests on top
  function automatic logic [DW-1:0] fold(input logic [DW-1:0] base,
                                         input logic [DW-1:0] orv,
                                         input logic [DW-1:0] andv,
                                         input logic [DW-1:0] setv);
    return ((base | orv) & andv) | setv;
  endfunction

  always_comb begin
    base_w = wr_main ? wdata : val_q;
    val_d  = fold(base_w, or_q, and_q, set_req);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= RST_VAL;
      or_q  <= ALL_ZERO;
      and_q <= ALL_ONE;
    end else begin
      val_q <= val_d;
      or_q  <= (kind == WK_OR)  ? wdata : ALL_ZERO;
      and_q <= (kind == WK_AND) ? wdata : ALL_ONE;
    end
  end

  assign value    = val_q;
  assign or_view  = or_q;
  assign and_view = and_q;

  // R3
  or_alias_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (or_pending && !and_pending) |=> ((value & $past(or_q)) == $past(or_q)));

  // R4
  and_alias_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (and_pending && !set_hit) |=> ((value & ~$past(and_q)) == ALL_ZERO));

  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_hit |=> ((value & $past(set_req)) == $past(set_req)));

endmodule

// File: rtl/irqp_poll.sv
module irqp_poll
  import irqp_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned IRQ_W = IRQ_FIELD_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [DW-1:0]  pres,
  input  logic           type_gate,
  input  logic [DW-1:0]  pmask,
  output logic [DW-1:0]  status,
  output logic           irq
);

  localparam int unsigned IDX_A = msb_idx(DW, POLL_BIT_A);
  localparam int unsigned IDX_B = msb_idx(DW, POLL_BIT_B);

  function automatic logic [DW-1:0] watch_mask();
    logic [DW-1:0] m;
    m = '0;
    for (int unsigned k = 0; k < DW; k++)
      if (poll_watched(k)) m[msb_idx(DW, k)] = 1'b1;
    return m;
  endfunction

  localparam logic [DW-1:0] WATCH = watch_mask();

  logic          src_live, type_open;
  logic [DW-1:0] cand, stat_d, stat_q;

  assign src_live  = |pres;
  assign type_open = ~type_gate;
  assign cand      = {DW{src_live & type_open}} & ~pmask;

  for (genvar k = 0; k < DW; k++) begin : g_bit
    if (WATCH[k]) begin : g_on
      assign stat_d[k] = cand[k];
    end else begin : g_off
      assign stat_d[k] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  assign status = stat_q;
  assign irq    = |stat_q[DW-1 -: IRQ_W];

  // R7
  poll_a_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_live && type_open && !pmask[IDX_A]) |=> status[IDX_A]);

  // R7
  poll_a_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(src_live && type_open && !pmask[IDX_A]) |=> !status[IDX_A]);

  // R8
  poll_b_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_live && type_open && !pmask[IDX_B]) |=> status[IDX_B]);

  // R10
  irq_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(src_live));

endmodule

// File: rtl/irq_poll_unit.sv
module irq_poll_unit
  import irqp_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [DW-1:0]  wr_data,
  input  logic [DW-1:0]  set_req,
  input  logic [AW-1:0]  rd_addr,
  output logic [DW-1:0]  rd_data,
  output logic [DW-1:0]  poll_status,
  output logic           local_err_irq
);

  localparam int unsigned NREG     = 2;
  localparam int unsigned GATE_IDX = msb_idx(DW, TYPE_GATE_BIT);
  localparam int unsigned BASES [NREG] = '{OFF_PRES, OFF_TYPE};

  function automatic wr_kind_e kind_for(input logic en, input logic [AW-1:0] a,
                                        input int unsigned base);
    if (!en)                        return WK_NONE;
    if (a == AW'(base))             return WK_DIRECT;
    if (a == AW'(base + 1))         return WK_OR;
    if (a == AW'(base + 2))         return WK_AND;
    return WK_NONE;
  endfunction

  logic [DW-1:0] val_w [NREG];
  logic [DW-1:0] orv_w [NREG];
  logic [DW-1:0] andv_w[NREG];
  logic [DW-1:0] pmask_q;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    wr_kind_e      kind_w;
    logic [DW-1:0] set_w;
    assign kind_w = kind_for(wr_en, wr_addr, BASES[i]);
    if (i == 0) begin : g_src
      assign set_w = set_req;
    end else begin : g_nosrc
      assign set_w = '0;
    end
    irqp_alias_reg #(.DW(DW), .RST_VAL('0)) u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .kind    (kind_w),
      .wdata   (wr_data),
      .set_req (set_w),
      .value   (val_w[i]),
      .or_view (orv_w[i]),
      .and_view(andv_w[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                       pmask_q <= '1;
    else if (wr_en && wr_addr == AW'(OFF_PMASK))      pmask_q <= wr_data;
  end

  irqp_poll #(.DW(DW), .IRQ_W(IRQ_FIELD_W)) u_poll (
    .clk      (clk),
    .rst_n    (rst_n),
    .pres     (val_w[0]),
    .type_gate(val_w[1][GATE_IDX]),
    .pmask    (pmask_q),
    .status   (poll_status),
    .irq      (local_err_irq)
  );

  always_comb begin
    rd_data = '0;
    if      (rd_addr == AW'(OFF_PRES))      rd_data = val_w[0];
    else if (rd_addr == AW'(OFF_PRES + 1))  rd_data = orv_w[0];
    else if (rd_addr == AW'(OFF_PRES + 2))  rd_data = andv_w[0];
    else if (rd_addr == AW'(OFF_TYPE))      rd_data = val_w[1];
    else if (rd_addr == AW'(OFF_TYPE + 1))  rd_data = orv_w[1];
    else if (rd_addr == AW'(OFF_TYPE + 2))  rd_data = andv_w[1];
    else if (rd_addr == AW'(OFF_PMASK))     rd_data = pmask_q;
    else if (rd_addr == AW'(OFF_STAT))      rd_data = poll_status;
  end

  // R2
  pmask_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == AW'(OFF_PMASK)) |=> (rd_addr != AW'(OFF_PMASK) || rd_data == $past(wr_data)));

endmodule

// File: tb/irq_poll_unit_tb.sv
`timescale 1ns/1ps
module irq_poll_unit_tb;
  localparam int DW = 32;
  localparam int AW = 5;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0, set_req = '0;
  wire  [DW-1:0] rd_data, poll_status;
  wire           local_err_irq;

  irq_poll_unit u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .set_req(set_req), .rd_addr(rd_addr), .rd_data(rd_data),
    .poll_status(poll_status), .local_err_irq(local_err_irq)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // Behavioural model
  logic [31:0] m_pres = 0, m_tm = 0, m_pm = '1, m_stat = 0;
  logic [31:0] m_por = 0, m_pand = '1, m_tor = 0, m_tand = '1;

  always @(posedge clk) begin
    logic [31:0] np, nt, ns;
    if (!rst_n) begin
      m_pres = 0; m_tm = 0; m_pm = '1; m_stat = 0;
      m_por = 0; m_pand = '1; m_tor = 0; m_tand = '1;
    end else begin
      ns = 0;
      for (int b = 0; b < 32; b++)
        if ((b == 3 || b == 7) && m_pres != 0 && m_tm[31] == 1'b0 && m_pm[31-b] == 1'b0)
          ns[31-b] = 1'b1;
      np = (wr_en && wr_addr == 5'd0)  ? wr_data : m_pres;
      nt = (wr_en && wr_addr == 5'd12) ? wr_data : m_tm;
      for (int b = 0; b < 32; b++) begin
        if (m_por[b])   np[b] = 1'b1;
        if (!m_pand[b]) np[b] = 1'b0;
        if (set_req[b]) np[b] = 1'b1;
        if (m_tor[b])   nt[b] = 1'b1;
        if (!m_tand[b]) nt[b] = 1'b0;
      end
      m_stat = ns;
      m_pres = np;
      m_tm   = nt;
      m_por  = (wr_en && wr_addr == 5'd1)  ? wr_data : 32'h0;
      m_pand = (wr_en && wr_addr == 5'd2)  ? wr_data : 32'hFFFF_FFFF;
      m_tor  = (wr_en && wr_addr == 5'd13) ? wr_data : 32'h0;
      m_tand = (wr_en && wr_addr == 5'd14) ? wr_data : 32'hFFFF_FFFF;
      if (wr_en && wr_addr == 5'd19) m_pm = wr_data;
    end
  end

  function automatic logic [31:0] m_read(input logic [AW-1:0] a);
    case (a)
      5'd0:  return m_pres;
      5'd1:  return m_por;
      5'd2:  return m_pand;
      5'd12: return m_tm;
      5'd13: return m_tor;
      5'd14: return m_tand;
      5'd19: return m_pm;
      5'd20: return m_stat;
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-clock comparison against the model
  always @(posedge clk) begin
    #5;
    if (rst_n && !done) begin
      chk("R9 status word", poll_status, m_stat);
      chk("R10 irq", {31'b0, local_err_irq}, {31'b0, |m_stat[31:28]});
      chk("R11 read", rd_data, m_read(rd_addr));
    end
  end

  task automatic bus_wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [AW-1:0] a, input logic [31:0] exp);
    rd_addr = a;
    #1;
    chk(tag, rd_data, exp);
  endtask

  task automatic out_chk(input string tag, input logic [31:0] st, input logic irq);
    chk(tag, poll_status, st);
    chk(tag, {31'b0, local_err_irq}, {31'b0, irq});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  localparam logic [4:0] ADDRS [9] = '{5'd0, 5'd1, 5'd2, 5'd12, 5'd13, 5'd14, 5'd19, 5'd5, 5'd20};

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset values
    rd_chk("R1 pres", 5'd0, 32'h0);
    rd_chk("R1 or alias", 5'd1, 32'h0);
    rd_chk("R1 and alias", 5'd2, 32'hFFFF_FFFF);
    rd_chk("R1 type", 5'd12, 32'h0);
    rd_chk("R1 type and alias", 5'd14, 32'hFFFF_FFFF);
    rd_chk("R1 pmask", 5'd19, 32'hFFFF_FFFF);
    out_chk("R1 outputs", 32'h0, 1'b0);

    // R3 set-bits alias
    bus_wr(5'd1, 32'h0000_00F0);
    rd_chk("R3 alias staged", 5'd1, 32'h0000_00F0);
    rd_chk("R3 pres not yet", 5'd0, 32'h0);
    @(negedge clk);
    rd_chk("R3 alias idle", 5'd1, 32'h0);
    rd_chk("R3 pres ored", 5'd0, 32'h0000_00F0);

    // R4 clear-bits alias
    bus_wr(5'd2, ~32'h0000_0010);
    rd_chk("R4 alias staged", 5'd2, ~32'h0000_0010);
    @(negedge clk);
    rd_chk("R4 alias idle", 5'd2, 32'hFFFF_FFFF);
    rd_chk("R4 pres anded", 5'd0, 32'h0000_00E0);

    // R2 direct write
    bus_wr(5'd0, 32'h8000_0001);
    rd_chk("R2 pres direct", 5'd0, 32'h8000_0001);

    // R7 unmask poll bit 3
    bus_wr(5'd19, ~(32'h1 << 28));
    rd_chk("R2 pmask direct", 5'd19, ~(32'h1 << 28));
    @(negedge clk);
    out_chk("R7 bit3 set", 32'h1000_0000, 1'b1);

    // R5 type mask aliases gate the status
    bus_wr(5'd13, 32'h8000_0000);
    rd_chk("R5 type or staged", 5'd13, 32'h8000_0000);
    repeat (2) @(negedge clk);
    rd_chk("R5 type ored", 5'd12, 32'h8000_0000);
    out_chk("R7 gated by type", 32'h0, 1'b0);
    bus_wr(5'd14, 32'h7FFF_FFFF);
    repeat (2) @(negedge clk);
    rd_chk("R5 type anded", 5'd12, 32'h0);
    out_chk("R5 status back", 32'h1000_0000, 1'b1);

    // R8 bit 7 alone does not raise the interrupt
    bus_wr(5'd19, ~(32'h1 << 24));
    @(negedge clk);
    out_chk("R8 bit7 only, R10 irq low", 32'h0100_0000, 1'b0);

    // R6 set request against a direct clear in the same cycle
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'd0; wr_data = 32'h0; set_req = 32'h4;
    @(negedge clk);
    wr_en = 1'b0; set_req = 32'h0;
    rd_chk("R6 set beats direct", 5'd0, 32'h4);
    // R6 set request against a staged clear landing on the same edge
    bus_wr(5'd2, 32'h0);
    set_req = 32'h2;
    @(negedge clk);
    set_req = 32'h0;
    rd_chk("R6 set beats staged clear", 5'd0, 32'h2);

    // R9 only bits 3 and 7 ever set
    bus_wr(5'd19, 32'h0);
    bus_wr(5'd0, 32'hFFFF_FFFF);
    @(negedge clk);
    out_chk("R9 both bits", 32'h1100_0000, 1'b1);

    // R11 status read and unmapped offset
    rd_chk("R11 status read", 5'd20, 32'h1100_0000);
    rd_chk("R11 unmapped", 5'd5, 32'h0);

    // Mixed random traffic, compared every clock
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      wr_en   = ($urandom % 2) == 0;
      wr_addr = ADDRS[$urandom % 7];
      case ($urandom % 4)
        0: wr_data = 32'h0;
        1: wr_data = 32'hFFFF_FFFF;
        2: wr_data = 32'h1 << ($urandom % 32);
        default: wr_data = $urandom;
      endcase
      set_req = (($urandom % 5) == 0) ? (32'h1 << ($urandom % 32)) : 32'h0;
      rd_addr = ADDRS[$urandom % 9];
    end
    @(negedge clk);
    wr_en = 1'b0; set_req = 32'h0;
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule